// File: doc/BRIEF.md
# Flash Program and Chip-Erase Sequencer

This block sits on the host side of a parallel NOR-style flash device. It takes single-word program requests and whole-chip erase requests from a user port. For each request it drives the fixed unlock and command write cycles onto a simple synchronous flash bus. It then polls the device's status bit until the embedded operation finishes, and confirms the result with a final read.

On the flash bus every write or read is a single-cycle strobe. Read data returns on `fb_rdata_i` in the cycle after the read strobe. The user port follows a request/busy/done handshake. The block refuses programs that would need a 0 bit turned back into a 1, when the caller supplies the current contents. A bounded poll count turns a hung device into a timeout, and the block then writes the read/reset command to return the device to read mode.

Command constants: unlock pair (`UA1`, 0xAA) then (`UA2`, 0x55); program setup 0xA0 at `UA1`; erase setup 0x80 at `UA1`; chip erase 0x10 at `UA1`; read/reset 0xF0 at the target address. Error code on `err_o`: 0 none, 1 verify mismatch, 2 timeout, 3 illegal bit raise.

Top module: `flash_pe_ctrl`

## Requirements
- R1: An accepted program request produces exactly four consecutive bus writes, starting the cycle after acceptance: (UA1,0xAA), (UA2,0x55), (UA1,0xA0), (target address, data).
- R2: An accepted chip-erase request produces exactly six consecutive bus writes, starting the cycle after acceptance: (UA1,0xAA), (UA2,0x55), (UA1,0x80), (UA1,0xAA), (UA2,0x55), (UA1,0x10).
- R3: After the command writes, every status read of a program uses the target address. Read data is taken the cycle after the read strobe. Polling ends when read bit 7 equals bit 7 of the programmed data.
- R4: For chip erase, polling ends only when read bit 7 is 1.
- R5: After polling ends, one more read is made at the same address. If it differs from the expected value (the data for a program, all ones for an erase), the operation completes with `err_o` = 1; otherwise with `err_o` = 0.
- R6: If POLL_MAX status reads all fail, the block writes 0xF0 (read/reset) and then completes with `err_o` = 2.
- R7: A program request with `cur_valid_i` = 1 and any bit set in `data_i` that is clear in `cur_i` completes in the next cycle with `err_o` = 3 and makes no bus access.
- R8: `busy_o` rises in the cycle after acceptance and stays high through the single-cycle `done_o` pulse. Requests that arrive while busy are ignored.
- R9: After reset, `busy_o`, `done_o`, `fb_we_o` and `fb_re_o` are 0 and `err_o` is 0.
- R10: The bus never writes and reads in the same cycle, and makes no access while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, taken when idle |
| op_i | input | 1 | 0 program, 1 chip erase |
| addr_i | input | AW | Target address (also the poll address for erase) |
| data_i | input | DW | Data to program |
| cur_valid_i | input | 1 | `cur_i` holds the current contents of the target |
| cur_i | input | DW | Current contents of the target |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result code, held until the next acceptance |
| fb_we_o | output | 1 | Flash bus write strobe |
| fb_re_o | output | 1 | Flash bus read strobe |
| fb_addr_o | output | AW | Flash bus address |
| fb_wdata_o | output | DW | Flash bus write data |
| fb_rdata_i | input | DW | Flash bus read data, valid the cycle after `fb_re_o` |

## Verification
The assertions check the following on every cycle:
- a write or read strobe never appears outside an operation, and the two strobes are never both active;
- `done_o` is a single pulse, and busy stays up until that pulse;
- an accepted request starts writing on the next cycle;
- every program status read carries the latched target address;
- an illegal bit raise completes on the next cycle with code 3;
- a timeout is always preceded by the read/reset write.

Only the bench's scenarios can show some of this behaviour, because it needs a device model that holds contents and a busy time. That covers the exact contents and order of the unlock sequences, the bit-7 stopping rules, and the verify mismatch caused by a bit that cannot be raised. It also covers the rule that a request made mid-operation leaves the bus untouched.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_VERIFY  = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_ILLEGAL = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_POLL_RD, ST_POLL_CHK,
    ST_VER_RD, ST_VER_CHK, ST_ABORT, ST_DONE
  } state_e;

  localparam int PROG_LEN  = 4;
  localparam int ERASE_LEN = 6;
  localparam int POLL_BIT  = 7;
  localparam int STEP_W    = 3;

  localparam logic [7:0] K_UNLOCK1 = 8'hAA;
  localparam logic [7:0] K_UNLOCK2 = 8'h55;
  localparam logic [7:0] K_PROG    = 8'hA0;
  localparam logic [7:0] K_ERASE   = 8'h80;
  localparam logic [7:0] K_CHIP    = 8'h10;
  localparam logic [7:0] K_RESET   = 8'hF0;
endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_pe_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [AW-1:0] UA1 = '0,
  parameter logic [AW-1:0] UA2 = '0
) (
  input  logic                op_i,
  input  logic [STEP_W-1:0]   step_i,
  input  logic [AW-1:0]       tgt_addr_i,
  input  logic [DW-1:0]       tgt_data_i,
  output logic [AW-1:0]       addr_o,
  output logic [DW-1:0]       data_o,
  output logic                last_o
);
  always_comb begin
    addr_o = UA1;
    data_o = DW'(K_UNLOCK1);
    if (!op_i) begin
      last_o = (step_i == STEP_W'(PROG_LEN - 1));
      unique case (step_i)
        3'd0:    begin addr_o = UA1; data_o = DW'(K_UNLOCK1); end
        3'd1:    begin addr_o = UA2; data_o = DW'(K_UNLOCK2); end
        3'd2:    begin addr_o = UA1; data_o = DW'(K_PROG);    end
        default: begin addr_o = tgt_addr_i; data_o = tgt_data_i; end
      endcase
    end else begin
      last_o = (step_i == STEP_W'(ERASE_LEN - 1));
      unique case (step_i)
        3'd0, 3'd3: begin addr_o = UA1; data_o = DW'(K_UNLOCK1); end
        3'd1, 3'd4: begin addr_o = UA2; data_o = DW'(K_UNLOCK2); end
        3'd2:       begin addr_o = UA1; data_o = DW'(K_ERASE);   end
        default:    begin addr_o = UA1; data_o = DW'(K_CHIP);    end
      endcase
    end
  end
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int MAX = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX) + 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX - 1));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int POLL_MAX = 1024,
  parameter logic [AW-1:0] UA1 = AW'(12'h555),
  parameter logic [AW-1:0] UA2 = AW'(12'h2AA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          cur_valid_i,
  input  logic [DW-1:0] cur_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    err_o,
  output logic          fb_we_o,
  output logic          fb_re_o,
  output logic [AW-1:0] fb_addr_o,
  output logic [DW-1:0] fb_wdata_o,
  input  logic [DW-1:0] fb_rdata_i
);
  state_e              state_q, state_d;
  logic                op_q;
  logic [AW-1:0]       addr_q;
  logic [DW-1:0]       exp_q;
  logic [STEP_W-1:0]   step_q;
  err_e                err_q;

  logic          accept, illegal, match, poll_last, cmd_last;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  assign accept  = (state_q == ST_IDLE) && req_i;
  assign illegal = !op_i && cur_valid_i && |(data_i & ~cur_i);
  assign match   = (fb_rdata_i[POLL_BIT] == exp_q[POLL_BIT]);

  flash_cmd_rom #(.AW(AW), .DW(DW), .UA1(UA1), .UA2(UA2)) u_rom (
    .op_i      (op_q),
    .step_i    (step_q),
    .tgt_addr_i(addr_q),
    .tgt_data_i(exp_q),
    .addr_o    (cmd_addr),
    .data_o    (cmd_data),
    .last_o    (cmd_last)
  );

  flash_poll_timer #(.MAX(POLL_MAX)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .inc_i ((state_q == ST_POLL_CHK) && !match),
    .last_o(poll_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_i) state_d = illegal ? ST_DONE : ST_CMD;
      ST_CMD:      if (cmd_last) state_d = ST_POLL_RD;
      ST_POLL_RD:  state_d = ST_POLL_CHK;
      ST_POLL_CHK: begin
        if (match)          state_d = ST_VER_RD;
        else if (poll_last) state_d = ST_ABORT;
        else                state_d = ST_POLL_RD;
      end
      ST_VER_RD:   state_d = ST_VER_CHK;
      ST_VER_CHK:  state_d = ST_DONE;
      ST_ABORT:    state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= 1'b0;
      addr_q  <= '0;
      exp_q   <= '0;
      step_q  <= '0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= op_i;
        addr_q <= addr_i;
        exp_q  <= op_i ? '1 : data_i;  // erased cells read all ones
        step_q <= '0;
        err_q  <= illegal ? ERR_ILLEGAL : ERR_NONE;
      end
      if (state_q == ST_CMD)     step_q <= step_q + 1'b1;
      if (state_q == ST_VER_CHK) err_q  <= (fb_rdata_i == exp_q) ? ERR_NONE : ERR_VERIFY;
      if (state_q == ST_ABORT)   err_q  <= ERR_TIMEOUT;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign err_o      = err_q;
  assign fb_we_o    = (state_q == ST_CMD) || (state_q == ST_ABORT);
  assign fb_re_o    = (state_q == ST_POLL_RD) || (state_q == ST_VER_RD);
  assign fb_addr_o  = (state_q == ST_CMD) ? cmd_addr : addr_q;
  assign fb_wdata_o = (state_q == ST_CMD) ? cmd_data : DW'(K_RESET);
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          op_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] data_i,
  input logic          cur_valid_i,
  input logic [DW-1:0] cur_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    err_o,
  input logic          fb_we_o,
  input logic          fb_re_o,
  input logic [AW-1:0] fb_addr_o,
  input logic [DW-1:0] fb_wdata_o
);
  logic          lat_prog;
  logic [AW-1:0] lat_addr;
  logic          take, bad_raise;

  assign take      = !busy_o && req_i;
  assign bad_raise = !op_i && cur_valid_i && |(data_i & ~cur_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_prog <= 1'b0;
      lat_addr <= '0;
    end else if (take) begin
      lat_prog <= !op_i;
      lat_addr <= addr_i;
    end
  end

  // R10
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fb_we_o && fb_re_o));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!fb_we_o && !fb_re_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R1
  start_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !bad_raise) |=> (fb_we_o && busy_o));
  // R7
  illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && bad_raise) |=> (done_o && err_o == 2'd3 && !fb_we_o && !fb_re_o));
  // R3
  poll_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_re_o && lat_prog) |-> (fb_addr_o == lat_addr));
  // R6
  timeout_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 2'd2) |-> $past(fb_we_o && fb_wdata_o == DW'(8'hF0)));
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
  .data_i(data_i), .cur_valid_i(cur_valid_i), .cur_i(cur_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .fb_we_o(fb_we_o), .fb_re_o(fb_re_o),
  .fb_addr_o(fb_addr_o), .fb_wdata_o(fb_wdata_o)
);

// File: tb/flash_pe_ctrl_bench.sv
module flash_pe_ctrl_bench;
  localparam int AW = 12, DW = 8, PMAX = 16;
  localparam logic [11:0] A1 = 12'h555, A2 = 12'h2AA;

  logic clk = 0, rst_n = 0;
  logic req = 0, op = 0, cv = 0;
  logic [11:0] addr = 0;
  logic [7:0]  data = 0, cur = 0;
  logic busy, done, we, re;
  logic [1:0] err;
  logic [11:0] fa;
  logic [7:0] fwd, frd = 0;

  always #10 clk = ~clk;

  flash_pe_ctrl #(.AW(AW), .DW(DW), .POLL_MAX(PMAX)) u_flash_pe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .data_i(data), .cur_valid_i(cv), .cur_i(cur), .busy_o(busy), .done_o(done),
    .err_o(err), .fb_we_o(we), .fb_re_o(re), .fb_addr_o(fa), .fb_wdata_o(fwd),
    .fb_rdata_i(frd)
  );

  // device model
  logic [7:0]  mem [4096];
  logic [11:0] ha [5];
  logic [7:0]  hd [5];
  int busy_cnt = 0, lat = 1, cyc = 0, wn = 0, rd_bad = 0;
  bit stuck = 0, t_prog = 0;
  logic [11:0] t_addr = 0, pend_a = 0;
  logic [7:0]  pend_d = 0;
  bit pend_erase = 0;
  logic [11:0] wlog_a [4096];
  logic [7:0]  wlog_d [4096];
  int          wlog_c [4096];

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < 5; i++) begin ha[i] = 12'hFFF; hd[i] = 8'h00; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (re) begin
      frd <= (busy_cnt > 0) ? (pend_erase ? 8'h00 : {~pend_d[7], 7'h00}) : mem[fa];
      if (t_prog && fa != t_addr) rd_bad <= rd_bad + 1;
    end
    if (busy_cnt > 0 && !stuck) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) begin
        if (pend_erase) for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
        else mem[pend_a] <= mem[pend_a] & pend_d;
      end
    end
    if (we) begin
      wlog_a[wn] <= fa; wlog_d[wn] <= fwd; wlog_c[wn] <= cyc; wn <= wn + 1;
      if (fwd == 8'hF0) begin
        busy_cnt <= 0;
        for (int i = 0; i < 5; i++) ha[i] <= 12'hFFF;
      end else if (busy_cnt == 0) begin
        if (ha[2] == A1 && hd[2] == 8'hAA && ha[1] == A2 && hd[1] == 8'h55 &&
            ha[0] == A1 && hd[0] == 8'hA0) begin
          pend_a <= fa; pend_d <= fwd; pend_erase <= 0; busy_cnt <= lat;
          for (int i = 0; i < 5; i++) ha[i] <= 12'hFFF;
        end else if (fa == A1 && fwd == 8'h10 && ha[0] == A2 && hd[0] == 8'h55 &&
                     ha[1] == A1 && hd[1] == 8'hAA && ha[2] == A1 && hd[2] == 8'h80 &&
                     ha[3] == A2 && hd[3] == 8'h55 && ha[4] == A1 && hd[4] == 8'hAA) begin
          pend_erase <= 1; busy_cnt <= lat;
          for (int i = 0; i < 5; i++) ha[i] <= 12'hFFF;
        end else begin
          for (int k = 4; k > 0; k--) begin ha[k] <= ha[k-1]; hd[k] <= hd[k-1]; end
          ha[0] <= fa; hd[0] <= fwd;
        end
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_wr(input bit e, input int i, input logic [11:0] a,
                                         input logic [7:0] d);
    if (!e) begin
      case (i)
        0: return {A1, 8'hAA};
        1: return {A2, 8'h55};
        2: return {A1, 8'hA0};
        default: return {a, d};
      endcase
    end
    case (i)
      0, 3: return {A1, 8'hAA};
      1, 4: return {A2, 8'h55};
      2: return {A1, 8'h80};
      default: return {A1, 8'h10};
    endcase
  endfunction

  function automatic logic [1:0] predict(input bit e, input logic [11:0] a, input logic [7:0] d,
                                         input bit v, input logic [7:0] c, input bit hang);
    logic [7:0] nv;
    if (e) return hang ? 2'd2 : 2'd0;
    if (v && |(d & ~c)) return 2'd3;
    nv = mem[a] & d;
    if (nv[7] != d[7]) return 2'd2;
    if (nv != d) return 2'd1;
    return 2'd0;
  endfunction

  task automatic run_op(input bit e, input logic [11:0] a, input logic [7:0] d,
                        input bit v, input logic [7:0] c, input int inj, input string tag);
    int n0, c0, t, len, exp_n;
    logic [1:0] ee;
    ee = predict(e, a, d, v, c, stuck);
    len = e ? 6 : 4;
    exp_n = (ee == 2'd3) ? 0 : (len + ((ee == 2'd2) ? 1 : 0));
    @(negedge clk);
    n0 = wn; c0 = cyc;
    req = 1; op = e; addr = a; data = d; cv = v; cur = c;
    t_prog = !e; t_addr = a;
    @(negedge clk);
    req = 0;
    chk({tag, " R8 busy after accept"}, busy, 1);
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk); t++;
      if (inj > 0 && t == inj) begin req = 1; op = ~e; addr = a + 1; data = 8'h00; end
      else req = 0;
    end
    req = 0;
    chk({tag, " R8 done seen"}, done, 1);
    chk({tag, " R5 R6 R7 err code"}, err, ee);
    chk({tag, " R1 R2 R7 write count"}, wn - n0, exp_n);
    if (exp_n > 0 && (wn - n0) == exp_n) begin
      for (int i = 0; i < len; i++) begin
        chk({tag, " R1 R2 write content"}, {wlog_a[n0+i], wlog_d[n0+i]}, exp_wr(e, i, a, d));
        chk({tag, " R1 R2 write cycle"}, wlog_c[n0+i], c0 + 1 + i);
      end
      if (ee == 2'd2) chk({tag, " R6 reset write"}, wlog_d[n0+len], 8'hF0);
    end
    chk({tag, " R3 poll address"}, rd_bad, 0);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, done, 0);
    chk({tag, " R8 R10 idle"}, {busy, we, re}, 0);
    t_prog = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {busy, done, we, re, err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle after reset", {busy, done, we, re, err}, 0);

    lat = 5;
    run_op(1, 12'h000, 8'h00, 0, 8'h00, 0, "R2 R4 erase");
    chk("R4 R5 erase left ones", mem[12'h7], 8'hFF);
    run_op(0, 12'h003, 8'h12, 1, 8'hFF, 0, "R1 R3 program");
    run_op(0, 12'h003, 8'h92, 1, 8'h12, 0, "R7 raise refused");
    chk("R7 contents untouched", mem[12'h3], 8'h12);
    lat = 3;
    run_op(0, 12'h003, 8'h92, 0, 8'h00, 0, "R6 bit7 stuck");
    run_op(0, 12'h003, 8'h13, 0, 8'h00, 0, "R5 verify miss");
    lat = 9;
    run_op(0, 12'h004, 8'h55, 1, 8'hFF, 4, "R8 ignore busy req");
    repeat (10) @(negedge clk);
    chk("R8 no activity after ignored req", {busy, we, re}, 0);
    stuck = 1;
    run_op(1, 12'h001, 8'h00, 0, 8'h00, 0, "R6 erase hang");
    stuck = 0;
    lat = 1;
    run_op(0, 12'h005, 8'hFF, 1, 8'hFF, 0, "R1 min latency");

    for (int n = 0; n < 80; n++) begin
      logic [11:0] a;
      logic [7:0] d;
      bit v;
      a = 12'($urandom_range(0, 7));
      lat = $urandom_range(1, 10);
      v = ($urandom_range(0, 1) == 1);
      case ($urandom_range(0, 9))
        0:       d = 8'h00;
        1, 2, 3: d = 8'($urandom);
        default: d = mem[a] & 8'($urandom);
      endcase
      if ($urandom_range(0, 11) == 0) run_op(1, a, 8'h00, 0, 8'h00, 0, "R2 R4 rand erase");
      else run_op(0, a, d, v, mem[a], 0, "R1 R3 rand program");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule